// File: doc/BRIEF.md
# Byte-Coded Stack Machine Core

This core runs programs written in a compact stack instruction set. It fetches instructions one byte per cycle from a byte-wide instruction memory and executes them against an evaluation stack. The two topmost stack entries live in registers. Anything deeper is kept in a region of the 32-bit data memory that grows downward from a reset-time stack pointer. Memory operands use the same data port as that spill traffic.

Each opcode is one byte. Opcodes that carry an address or a branch target are followed by a 16-bit little-endian operand. Branch targets are absolute byte addresses in instruction memory. Data addresses index 32-bit words.

The core keeps three running counters: instruction bytes fetched, data bytes read and data bytes written. A word access counts as four bytes. These counters make the cost of stack spills visible. The core stops when it reaches a halt opcode, an undefined opcode, or an operation that needs more stack entries than the stack holds. Each of these stops is reported through its own status output.

Top module: `stack_core`

## Requirements
- R1: Opcodes are PUSH=0x01, POP=0x02, ADD=0x03, SUB=0x04, ZERO=0x05, INC=0x06, BEQZ=0x07, BNEZ=0x08 and GOTO=0x09. PUSH, POP, BEQZ, BNEZ and GOTO are three bytes long: the opcode, then the operand low byte, then the operand high byte. All other opcodes are one byte long. `fetch_bytes` rises by one for every instruction byte read, including the byte of a halting opcode.
- R2: PUSH a places the data word at word address a on top of the stack. POP a removes the top entry and writes it to word address a.
- R3: ADD removes two entries and pushes their sum. SUB removes two entries and pushes (second-from-top minus top). Both wrap modulo 2^32.
- R4: ZERO replaces the top entry with 0. INC replaces the top entry with its value plus one.
- R5: BEQZ removes the top entry and jumps to the operand if that entry is zero; otherwise it falls through. BNEZ removes the top entry and jumps if it is nonzero. GOTO always jumps.
- R6: A PUSH that finds two or more entries on the stack first writes the second entry to word address sp and then decrements sp. An entry-removing operation that starts with more than two entries reloads the second entry from word address sp+1 and then increments sp. sp resets to SP_INIT and equals SP_INIT whenever the stack holds at most one entry.
- R7: `rd_bytes` rises by 4 for every data-memory read. `wr_bytes` rises by 4 for every data-memory write. A read and a write never occur in the same cycle.
- R8: Opcode 0x00 stops the core with `halted` high. Once halted, the core makes no further fetches or data accesses until the next reset.
- R9: Any opcode from 0x0A to 0xFF sets `illegal` and halts the core.
- R10: An operation that finds fewer stack entries than it consumes sets `underflow` and halts, with no data write. ADD and SUB need two entries; POP, ZERO, INC, BEQZ and BNEZ need one.
- R11: While reset is asserted, all three counters read zero and all status flags are low. Execution starts at byte address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 16 | Instruction byte address |
| imem_data | input | 8 | Instruction byte at imem_addr, valid in the same cycle |
| dmem_addr | output | 16 | Data word address |
| dmem_rd | output | 1 | Data read strobe |
| dmem_wr | output | 1 | Data write strobe |
| dmem_wdata | output | DW | Data write value |
| dmem_rdata | input | DW | Data word at dmem_addr, valid in the same cycle |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Stopped on an undefined opcode |
| underflow | output | 1 | Stopped on a stack underflow |
| fetch_bytes | output | CW | Instruction bytes fetched |
| rd_bytes | output | CW | Data bytes read |
| wr_bytes | output | CW | Data bytes written |

## Verification
The bench builds the core with DW=32, CW=32 and SP_INIT=0x00FF. With that stack pointer, the whole spill region fits in a 256-word data memory model, so the bench can read back spilled words directly.

The bench sweeps several programs. A counted multiply-by-addition loop runs for trip counts 0 to 12. A push-then-add chain runs at depths 1 to 8, which moves the spill boundary through every position. The bench also tests every undefined opcode, a set of subtraction operand pairs that includes a negative result, and each kind of underflow. For each run, the expected results, spill contents and byte counts come from closed-form formulas in the trip count or the depth.

// File: rtl/stack_core.sv
module stack_core #(
  parameter int DW = 32,
  parameter int CW = 32,
  parameter logic [15:0] SP_INIT = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [15:0]   imem_addr,
  input  logic [7:0]    imem_data,
  output logic [15:0]   dmem_addr,
  output logic          dmem_rd,
  output logic          dmem_wr,
  output logic [DW-1:0] dmem_wdata,
  input  logic [DW-1:0] dmem_rdata,
  output logic          halted,
  output logic          illegal,
  output logic          underflow,
  output logic [CW-1:0] fetch_bytes,
  output logic [CW-1:0] rd_bytes,
  output logic [CW-1:0] wr_bytes
);
  localparam int AW = 16;
  localparam logic [7:0] OP_HALT = 8'h00, OP_PUSH = 8'h01, OP_POP = 8'h02,
                         OP_ADD = 8'h03, OP_SUB = 8'h04, OP_ZERO = 8'h05,
                         OP_INC = 8'h06, OP_BEQZ = 8'h07, OP_BNEZ = 8'h08,
                         OP_GOTO = 8'h09;
  localparam logic [AW:0]   N1 = 1, N2 = 2;
  localparam logic [AW-1:0] A1 = 1;
  localparam logic [DW-1:0] D1 = 1;
  localparam logic [CW-1:0] C1 = 1, C4 = 4;

  typedef enum logic [2:0] {S_OP, S_LO, S_HI, S_SPILL, S_EXEC, S_REFILL, S_HALT} st_t;

  st_t            st;
  logic [7:0]     op;
  logic [AW-1:0]  pc, opnd, sp;
  logic [AW:0]    depth, need;
  logic [DW-1:0]  t0, t1;
  logic           ok, pops;

  function automatic logic has_opnd(input logic [7:0] o);
    return o == OP_PUSH || o == OP_POP || o == OP_BEQZ || o == OP_BNEZ || o == OP_GOTO;
  endfunction

  assign imem_addr = pc;
  assign halted    = (st == S_HALT);
  assign pops      = op == OP_POP || op == OP_ADD || op == OP_SUB || op == OP_BEQZ || op == OP_BNEZ;
  assign need      = (op == OP_ADD || op == OP_SUB) ? N2 :
                     (pops || op == OP_ZERO || op == OP_INC) ? N1 : '0;
  assign ok        = depth >= need;

  always_comb begin
    dmem_addr  = '0;
    dmem_rd    = 1'b0;
    dmem_wr    = 1'b0;
    dmem_wdata = t0;
    case (st)
      S_SPILL: begin dmem_addr = sp; dmem_wr = 1'b1; dmem_wdata = t1; end
      S_EXEC: if (ok) begin
        if (op == OP_PUSH) begin dmem_addr = opnd; dmem_rd = 1'b1; end
        else if (op == OP_POP) begin dmem_addr = opnd; dmem_wr = 1'b1; end
      end
      S_REFILL: begin dmem_addr = sp + A1; dmem_rd = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_bytes <= '0;
      rd_bytes    <= '0;
      wr_bytes    <= '0;
    end else begin
      if (st == S_OP || st == S_LO || st == S_HI) fetch_bytes <= fetch_bytes + C1;
      if (dmem_rd) rd_bytes <= rd_bytes + C4;
      if (dmem_wr) wr_bytes <= wr_bytes + C4;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_OP; op <= '0; pc <= '0; opnd <= '0; sp <= SP_INIT;
      depth <= '0; t0 <= '0; t1 <= '0; illegal <= 1'b0; underflow <= 1'b0;
    end else begin
      case (st)
        S_OP: begin
          op <= imem_data;
          pc <= pc + A1;
          if (imem_data == OP_HALT) st <= S_HALT;
          else if (imem_data > OP_GOTO) begin illegal <= 1'b1; st <= S_HALT; end
          else st <= has_opnd(imem_data) ? S_LO : S_EXEC;
        end
        S_LO: begin opnd[7:0] <= imem_data; pc <= pc + A1; st <= S_HI; end
        S_HI: begin
          opnd[15:8] <= imem_data;
          pc <= pc + A1;
          st <= (op == OP_PUSH && depth >= N2) ? S_SPILL : S_EXEC;
        end
        S_SPILL: begin sp <= sp - A1; st <= S_EXEC; end
        S_EXEC: begin
          if (!ok) begin
            underflow <= 1'b1;
            st <= S_HALT;
          end else begin
            st <= (pops && depth > N2) ? S_REFILL : S_OP;
            case (op)
              OP_PUSH: begin t1 <= t0; t0 <= dmem_rdata; depth <= depth + N1; end
              OP_POP:  begin t0 <= t1; depth <= depth - N1; end
              OP_ADD:  begin t0 <= t1 + t0; depth <= depth - N1; end
              OP_SUB:  begin t0 <= t1 - t0; depth <= depth - N1; end
              OP_ZERO: t0 <= '0;
              OP_INC:  t0 <= t0 + D1;
              OP_BEQZ: begin
                t0 <= t1; depth <= depth - N1;
                if (t0 == '0) pc <= opnd;
              end
              OP_BNEZ: begin
                t0 <= t1; depth <= depth - N1;
                if (t0 != '0) pc <= opnd;
              end
              OP_GOTO: pc <= opnd;
              default: ;
            endcase
          end
        end
        S_REFILL: begin sp <= sp + A1; t1 <= dmem_rdata; st <= S_OP; end
        default: st <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/stack_core_chk.sv
module stack_core_chk #(
  parameter int CW = 32,
  parameter logic [15:0] SP_INIT = 16'hFFFF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dmem_rd,
  input logic          dmem_wr,
  input logic          halted,
  input logic          illegal,
  input logic          underflow,
  input logic [CW-1:0] fetch_bytes,
  input logic [CW-1:0] rd_bytes,
  input logic [CW-1:0] wr_bytes,
  input logic [16:0]   depth,
  input logic [15:0]   sp
);
  assert_rdwr_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_rd && dmem_wr));
  assert_rd_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_rd |=> rd_bytes == $past(rd_bytes) + 4);
  assert_wr_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_wr |=> wr_bytes == $past(wr_bytes) + 4);
  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(fetch_bytes) && !dmem_rd && !dmem_wr);
  assert_illegal_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> halted);
  assert_underflow_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> halted && !dmem_wr);
  assert_one_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal, underflow}));
  assert_sp_home_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (depth <= 17'd1) |-> (sp == SP_INIT));
endmodule

bind stack_core stack_core_chk #(.CW(CW), .SP_INIT(SP_INIT)) u_chk (.*);

// File: tb/test_stack_core.sv
`timescale 1ns/1ps
module test_stack_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] imem_addr, dmem_addr;
  logic [7:0]  imem_data;
  logic        dmem_rd, dmem_wr, halted, illegal, underflow;
  logic [31:0] dmem_wdata, dmem_rdata, fetch_bytes, rd_bytes, wr_bytes;
  logic [7:0]  imem [0:255];
  logic [31:0] dmem [0:255];
  int checks = 0, errors = 0, wp = 0;

  always #2.5 clk = ~clk;

  stack_core #(.DW(32), .CW(32), .SP_INIT(16'h00FF)) i_stack_core (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .halted(halted),
    .illegal(illegal), .underflow(underflow), .fetch_bytes(fetch_bytes),
    .rd_bytes(rd_bytes), .wr_bytes(wr_bytes));

  assign imem_data  = imem[imem_addr[7:0]];
  assign dmem_rdata = dmem[dmem_addr[7:0]];
  always @(posedge clk) if (dmem_wr) dmem[dmem_addr[7:0]] <= dmem_wdata;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear();
    for (int i = 0; i < 256; i++) begin imem[i] = 8'h00; dmem[i] = 32'h0; end
    wp = 0;
  endtask

  task automatic put1(input logic [7:0] o);
    imem[wp] = o; wp++;
  endtask

  task automatic put3(input logic [7:0] o, input logic [15:0] a);
    imem[wp] = o; imem[wp+1] = a[7:0]; imem[wp+2] = a[15:8]; wp += 3;
  endtask

  task automatic run();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 5000 && !halted; c++) @(negedge clk);
    if (!halted) check("R8 run did not halt", 32'h0, 32'h1);
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear();
    repeat (3) @(negedge clk);
    check("R11 fetch at reset", fetch_bytes, 0);
    check("R11 rd at reset", rd_bytes, 0);
    check("R11 wr at reset", wr_bytes, 0);
    check("R11 flags at reset", {29'h0, halted, illegal, underflow}, 0);
    check("R11 pc at reset", {16'h0, imem_addr}, 0);

    // counted loop: result += a, b times (R1 R2 R3 R5 R7)
    for (int b = 0; b <= 12; b++) begin
      logic [31:0] a;
      a = 32'(b) * 32'h0101_0007 + 32'd3;
      clear();
      dmem[8'h10] = 32'(b); dmem[8'h11] = a;
      put3(8'h01, 16'h0013); put3(8'h01, 16'h0010); put1(8'h04);
      put3(8'h07, 16'd30);
      put3(8'h01, 16'h0012); put3(8'h01, 16'h0011); put1(8'h03); put3(8'h02, 16'h0012);
      put3(8'h01, 16'h0013); put1(8'h06); put3(8'h02, 16'h0013);
      put3(8'h09, 16'd0);
      put1(8'h00);
      run();
      check("R3 loop product", dmem[8'h12], a * 32'(b));
      check("R4 loop counter", dmem[8'h13], 32'(b));
      check("R1 loop fetch bytes", fetch_bytes, 32'(30 * b + 11));
      check("R7 loop read bytes", rd_bytes, 32'(20 * b + 8));
      check("R7 loop write bytes", wr_bytes, 32'(8 * b));
      check("R8 loop halt flags", {29'h0, halted, illegal, underflow}, 32'h4);
      if (b == 3) begin
        repeat (20) @(negedge clk);
        check("R8 no fetch after halt", fetch_bytes, 32'(30 * b + 11));
      end
    end

    // push chain then add chain: spills and refills (R6 R7)
    for (int n = 1; n <= 8; n++) begin
      logic [31:0] sum;
      int extra;
      clear();
      sum = 0;
      extra = (n > 2) ? n - 2 : 0;
      for (int k = 0; k < n; k++) begin
        dmem[8'h20 + k] = 32'(k) * 32'h1000_0001 + 32'(k * k) + 32'd1;
        sum += dmem[8'h20 + k];
        put3(8'h01, 16'(8'h20 + k));
      end
      for (int k = 1; k < n; k++) put1(8'h03);
      put3(8'h02, 16'h0030);
      put1(8'h00);
      run();
      check("R6 chain sum", dmem[8'h30], sum);
      check("R1 chain fetch bytes", fetch_bytes, 32'(4 * n + 3));
      check("R6 chain read bytes", rd_bytes, 32'(4 * (n + extra)));
      check("R6 chain write bytes", wr_bytes, 32'(4 * (1 + extra)));
      if (n >= 3) check("R6 spill slot", dmem[8'hFF], 32'h1);
      check("R10 chain no underflow", {31'h0, underflow}, 0);
    end

    // SUB order, INC and ZERO (R3 R4)
    for (int i = 0; i <= 5; i++) begin
      logic [31:0] x, y;
      x = 32'(i) * 32'h3000_0001;
      y = 32'(5 - i) * 32'h2000_0003;
      clear();
      dmem[8'h40] = x; dmem[8'h41] = y;
      put3(8'h01, 16'h0040); put3(8'h01, 16'h0041); put1(8'h04); put1(8'h06);
      put3(8'h02, 16'h0042);
      put3(8'h01, 16'h0040); put1(8'h05); put1(8'h06); put1(8'h06);
      put3(8'h02, 16'h0043);
      put1(8'h00);
      run();
      check("R3 sub second minus top", dmem[8'h42], x - y + 32'd1);
      check("R4 zero then inc", dmem[8'h43], 32'd2);
    end

    // BNEZ taken / not taken (R5)
    for (int i = 0; i < 3; i++) begin
      logic [31:0] v;
      v = (i == 0) ? 32'h0 : (i == 1) ? 32'h1 : 32'hFFFF_FFFF;
      clear();
      dmem[8'h44] = v; dmem[8'h45] = 32'hDEAD;
      put3(8'h01, 16'h0044); put3(8'h08, 16'd10); put1(8'h00);
      wp = 10;
      put3(8'h01, 16'h0044); put1(8'h06); put3(8'h02, 16'h0045); put1(8'h00);
      run();
      check("R5 bnez result", dmem[8'h45], (v != 0) ? v + 32'd1 : 32'hDEAD);
      check("R5 bnez fetch bytes", fetch_bytes, (v != 0) ? 32'd14 : 32'd7);
    end

    // every undefined opcode (R9)
    for (int o = 10; o < 256; o++) begin
      clear();
      put1(8'(o));
      run();
      check("R9 illegal flag", {30'h0, illegal, underflow}, 32'h2);
      check("R9 illegal fetch bytes", fetch_bytes, 32'd1);
    end
    clear(); run();
    check("R8 zero opcode halts clean", {29'h0, halted, illegal, underflow}, 32'h4);

    // underflow cases (R10)
    clear();
    dmem[8'h44] = 32'h7;
    put3(8'h01, 16'h0044); put1(8'h03);
    run();
    check("R10 add on one entry", {30'h0, illegal, underflow}, 32'h1);
    check("R10 add fetch bytes", fetch_bytes, 32'd4);
    clear();
    dmem[8'h50] = 32'h1234;
    put3(8'h02, 16'h0050);
    run();
    check("R10 pop on empty flag", {31'h0, underflow}, 32'h1);
    check("R10 pop on empty no write", wr_bytes, 32'd0);
    check("R10 pop on empty memory", dmem[8'h50], 32'h1234);
    clear();
    put1(8'h06);
    run();
    check("R10 inc on empty", {31'h0, underflow}, 32'h1);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R11 flags cleared by reset", {29'h0, halted, illegal, underflow}, 0);
    check("R11 fetch cleared by reset", fetch_bytes, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule